// File: doc/BRIEF.md
# Flash Controller Event Status and Interrupt Unit

This block holds the event and status state of a serial flash controller. The FIFOs and the transfer engine send it one-cycle event pulses. These are receive full, receive underflow, transmit overflow, transmit empty, transfer done, bus error, protocol error and DMA done. Each pulse sets a sticky bit in a raw status vector. A mask vector filters the raw vector into a masked view, and a single interrupt line is raised while any masked bit is set. Software writes ones into the clear port to acknowledge bits. Bits that are masked off still latch in the raw vector, so software must clear them as well.

The block also packs the FIFO fill levels and the derived full and empty flags into one status word. It reports whether the controller is idle or busy. It also runs a soft-recovery sequence that holds the state machine and FIFO reset for a fixed number of cycles. The recovery bit reads back as one until that reset is over. Register writes come in through a one-cycle write strobe with a selector. Every view is a parallel output.

Top module: `flash_stat_irq`

## Requirements
- R1: After reset the raw and masked status are 0, the mask is all ones, irq is 0, the recovery bit and the recovery reset are 0, and ctrl_busy follows engine_busy alone.
- R2: An event pulse on bit i sets raw_status[i] at the next clock edge. The bit stays set until it is cleared. The bits are 0 receive full, 1 receive underflow, 2 transmit overflow, 3 transmit empty, 4 transfer done, 5 bus error, 6 protocol error, 7 DMA done. The same bit positions are used in the mask, clear, raw and masked views.
- R3: A write with wr_sel=1 (clear) clears every raw bit whose wr_data bit is 1 and leaves the other raw bits unchanged.
- R4: If an event pulse and a clear for the same bit come in the same cycle, the bit is set after the edge.
- R5: A write with wr_sel=0 loads the mask from wr_data. masked_status equals raw_status AND NOT mask, so a mask bit of 1 disables that event, but the event is still latched in raw_status.
- R6: irq is 1 exactly when at least one masked_status bit is 1.
- R7: fifo_status holds the following fields, and every other bit is 0:
  - bit 0: transmit full (tx_level = DEPTH)
  - bit 1: transmit empty (tx_level = 0)
  - bit 2: receive empty (rx_level = 0)
  - bit 3: receive full (rx_level = DEPTH)
  - bits [12:8]: tx_level
  - bits [20:16]: rx_level
- R8: ctrl_busy reads 1 (busy) while engine_busy is high or a recovery reset is running, and 0 (idle) otherwise.
- R9: A write with wr_sel=2 and wr_data[0]=1 starts a recovery. recover_bit and recover_rst are 1 for exactly 4 cycles after the write edge and then clear by themselves. A write with wr_sel=2 and wr_data[0]=0 has no effect.
- R10: A recovery changes neither the mask nor the raw status.
- R11: A write with wr_sel=3 is ignored: raw status, mask and recovery stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 8 | One-cycle event pulses, one bit per event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 clear, 2 recovery, 3 none |
| wr_data | input | 8 | Write data |
| tx_level | input | 5 | Transmit FIFO fill level |
| rx_level | input | 5 | Receive FIFO fill level |
| engine_busy | input | 1 | Transfer engine is active |
| raw_status | output | 8 | Latched events, before masking |
| masked_status | output | 8 | Raw status with masked bits removed |
| mask_status | output | 8 | Current mask, 1 = event disabled |
| fifo_status | output | 32 | Packed FIFO flags and levels |
| ctrl_busy | output | 1 | 0 idle, 1 busy |
| recover_bit | output | 1 | Recovery bit read-back |
| recover_rst | output | 1 | Reset to the state machine and FIFOs during recovery |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- a pulsed event is present in the raw view after the edge;
- an acknowledged bit is gone unless a new pulse arrived in the same cycle;
- the interrupt line agrees with the raw and mask state;
- a recovery never runs longer than its fixed length;
- busy is reported during a recovery;
- the mask stays stable during a recovery.

Only the bench scenarios show:
- that a recovery lasts exactly four cycles and leaves the raw state intact;
- that writes to the unused selector, and recovery writes with bit 0 low, change nothing;
- the layout of the FIFO status word across its full and empty corners.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
    localparam int NUM_EVT = 8;

    localparam int EV_RX_FULL   = 0;
    localparam int EV_RX_UNDER  = 1;
    localparam int EV_TX_OVER   = 2;
    localparam int EV_TX_EMPTY  = 3;
    localparam int EV_XFER_DONE = 4;
    localparam int EV_BUS_ERR   = 5;
    localparam int EV_PROTO_ERR = 6;
    localparam int EV_DMA_DONE  = 7;

    typedef enum logic [1:0] {
        SEL_MASK    = 2'd0,
        SEL_CLEAR   = 2'd1,
        SEL_RECOVER = 2'd2,
        SEL_NONE    = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic [NUM_EVT-1:0] raw;
        logic [NUM_EVT-1:0] mask;
    } evt_state_t;
endpackage

// File: rtl/evt_latch.sv
module evt_latch
    import flash_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               clr_we,
    input  logic               mask_we,
    input  logic [NUM_EVT-1:0] wdata,
    output logic [NUM_EVT-1:0] raw,
    output logic [NUM_EVT-1:0] mask,
    output logic [NUM_EVT-1:0] masked
);
    evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) begin
            st_d.raw = st_q.raw & ~wdata;
        end
        // a pulse in the same cycle as a clear keeps the bit set
        st_d.raw = st_d.raw | evt;
        if (mask_we) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.raw  <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_EVT; gi++) begin : g_mask
            assign masked[gi] = st_q.raw[gi] & ~st_q.mask[gi];
        end
    endgenerate

    assign raw  = st_q.raw;
    assign mask = st_q.mask;
endmodule

// File: rtl/recover_seq.sv
module recover_seq #(
    parameter int REC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CNT_W = $clog2(REC_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REC_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rec_state_t;

    rec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (start) begin
            st_d.cnt = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.cnt != '0);
endmodule

// File: rtl/fifo_stat_pack.sv
module fifo_stat_pack #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    output logic [31:0]      word
);
    localparam int TX_POS = 8;
    localparam int RX_POS = 16;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    always_comb begin
        word = '0;
        word[0] = (tx_level == FULL_LVL);
        word[1] = (tx_level == '0);
        word[2] = (rx_level == '0);
        word[3] = (rx_level == FULL_LVL);
        word[TX_POS +: LVL_W] = tx_level;
        word[RX_POS +: LVL_W] = rx_level;
    end
endmodule

// File: rtl/flash_stat_irq.sv
module flash_stat_irq
    import flash_stat_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int LVL_W      = $clog2(DEPTH + 1),
    parameter int REC_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [NUM_EVT-1:0] wr_data,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic               engine_busy,
    output logic [NUM_EVT-1:0] raw_status,
    output logic [NUM_EVT-1:0] masked_status,
    output logic [NUM_EVT-1:0] mask_status,
    output logic [31:0]        fifo_status,
    output logic               ctrl_busy,
    output logic               recover_bit,
    output logic               recover_rst,
    output logic               irq
);
    logic clr_we, mask_we, rec_start, rec_active;

    assign clr_we    = wr_en && (wr_sel == SEL_CLEAR);
    assign mask_we   = wr_en && (wr_sel == SEL_MASK);
    assign rec_start = wr_en && (wr_sel == SEL_RECOVER) && wr_data[0];

    evt_latch u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_pulse),
        .clr_we (clr_we),
        .mask_we(mask_we),
        .wdata  (wr_data),
        .raw    (raw_status),
        .mask   (mask_status),
        .masked (masked_status)
    );

    recover_seq #(.REC_CYCLES(REC_CYCLES)) u_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rec_start),
        .active(rec_active)
    );

    fifo_stat_pack #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
        .tx_level(tx_level),
        .rx_level(rx_level),
        .word    (fifo_status)
    );

    assign recover_bit = rec_active;
    assign recover_rst = rec_active;
    assign ctrl_busy   = engine_busy | rec_active;
    assign irq         = |masked_status;
endmodule

// File: rtl/flash_stat_irq_chk.sv
module flash_stat_irq_chk
    import flash_stat_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic [NUM_EVT-1:0] wr_data,
    input logic [NUM_EVT-1:0] raw_status,
    input logic [NUM_EVT-1:0] mask_status,
    input logic               ctrl_busy,
    input logic               recover_rst,
    input logic               irq
);
    logic [3:0] rec_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_len <= '0;
        end else if (recover_rst) begin
            rec_len <= rec_len + 1'b1;
        end else begin
            rec_len <= '0;
        end
    end

    // R2: a pulsed event is latched after the edge
    a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((raw_status & $past(evt_pulse)) == $past(evt_pulse)));

    // R3 and R4: cleared bits are gone unless pulsed in the same cycle
    a_r3_clear_acts: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && wr_sel == SEL_CLEAR))
        |-> ((raw_status & $past(wr_data & ~evt_pulse)) == '0));

    // R6: interrupt agrees with raw state and mask
    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((raw_status & ~mask_status) != '0));

    // R9: recovery never longer than four cycles
    a_r9_rec_len: assert property (@(posedge clk) disable iff (!rst_n)
        rec_len <= 4'd4);

    // R8: busy reported during recovery
    a_r8_busy_in_rec: assert property (@(posedge clk) disable iff (!rst_n)
        recover_rst |-> ctrl_busy);

    // R10: mask unaffected by recovery
    a_r10_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (recover_rst && !(wr_en && wr_sel == SEL_MASK)) |=> $stable(mask_status));
endmodule

bind flash_stat_irq flash_stat_irq_chk u_chk (.*);

// File: tb/sim_flash_stat_irq.sv
module sim_flash_stat_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_pulse = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [4:0]  tx_level = '0;
    logic [4:0]  rx_level = '0;
    logic        engine_busy = 1'b0;
    logic [7:0]  raw_status, masked_status, mask_status;
    logic [31:0] fifo_status;
    logic        ctrl_busy, recover_bit, recover_rst, irq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    flash_stat_irq u0 (.*);

    // tx_level, rx_level, expected word (depth 16)
    localparam logic [41:0] FIFO_VEC [6] = '{
        {5'd0,  5'd0,  32'h0000_0006},
        {5'd16, 5'd0,  32'h0000_1005},
        {5'd3,  5'd16, 32'h0010_0308},
        {5'd0,  5'd16, 32'h0010_000A},
        {5'd7,  5'd9,  32'h0009_0700},
        {5'd16, 5'd16, 32'h0010_1009}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] ev, input logic we, input logic [1:0] sel,
                       input logic [7:0] d);
        @(negedge clk);
        evt_pulse = ev; wr_en = we; wr_sel = sel; wr_data = d;
        @(negedge clk);
        evt_pulse = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    endtask

    initial begin
        #4ms;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 raw", {24'h0, raw_status}, 32'h0);
        chk("R1 mask", {24'h0, mask_status}, 32'hFF);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 recover", {30'h0, recover_bit, recover_rst}, 32'h0);
        chk("R1 busy", {31'h0, ctrl_busy}, 32'h0);

        cyc(8'h01, 1'b0, 2'd0, 8'h00);
        chk("R2 rx full latched", {24'h0, raw_status}, 32'h01);
        cyc(8'h80, 1'b0, 2'd0, 8'h00);
        chk("R2 dma done sticky", {24'h0, raw_status}, 32'h81);
        chk("R5 all masked", {24'h0, masked_status}, 32'h00);
        chk("R6 irq off when masked", {31'h0, irq}, 32'h0);

        cyc(8'h00, 1'b1, 2'd0, 8'h7F);
        chk("R5 masked view", {24'h0, masked_status}, 32'h80);
        chk("R6 irq on", {31'h0, irq}, 32'h1);

        cyc(8'h00, 1'b1, 2'd1, 8'h01);
        chk("R3 partial clear", {24'h0, raw_status}, 32'h80);
        cyc(8'h00, 1'b1, 2'd1, 8'h80);
        chk("R3 full clear", {24'h0, raw_status}, 32'h00);
        chk("R6 irq drops", {31'h0, irq}, 32'h0);

        cyc(8'h10, 1'b1, 2'd1, 8'h10);
        chk("R4 event wins", {24'h0, raw_status}, 32'h10);
        cyc(8'h00, 1'b1, 2'd1, 8'h10);
        chk("R4 later clear", {24'h0, raw_status}, 32'h00);

        cyc(8'h05, 1'b0, 2'd0, 8'h00);
        cyc(8'h00, 1'b1, 2'd3, 8'hFF);
        chk("R11 raw kept", {24'h0, raw_status}, 32'h05);
        chk("R11 mask kept", {24'h0, mask_status}, 32'h7F);
        chk("R11 no recovery", {31'h0, recover_bit}, 32'h0);

        cyc(8'h00, 1'b1, 2'd2, 8'h00);
        chk("R9 bit0 low ignored", {31'h0, recover_bit}, 32'h0);

        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        chk("R8 busy in recovery", {31'h0, ctrl_busy}, 32'h1);
        hi = 0;
        for (int k = 0; k < 8; k++) begin
            if (recover_bit && recover_rst) hi++;
            @(negedge clk);
        end
        chk("R9 recovery length", hi, 4);
        chk("R9 self clear", {30'h0, recover_bit, recover_rst}, 32'h0);
        chk("R10 raw after recovery", {24'h0, raw_status}, 32'h05);
        chk("R10 mask after recovery", {24'h0, mask_status}, 32'h7F);
        chk("R8 idle", {31'h0, ctrl_busy}, 32'h0);
        engine_busy = 1'b1;
        #1;
        chk("R8 engine busy", {31'h0, ctrl_busy}, 32'h1);
        engine_busy = 1'b0;

        for (int v = 0; v < 6; v++) begin
            tx_level = FIFO_VEC[v][41:37];
            rx_level = FIFO_VEC[v][36:32];
            #1;
            chk("R7 fifo word", fifo_status, FIFO_VEC[v][31:0]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule